// File: doc/BRIEF.md
# Tag Check Fault Policy Unit

This block decides the consequence of a failed memory tag check. When the check logic pulses a failure strobe, it presents the faulting address, whether the access was a store, the exception level of the access, and the system control word that governs that level. The block takes a 2-bit check-fault mode from that word. At the unprivileged level the mode comes from one field. At every other level it comes from a second field.

The mode selects one of four outcomes. The failure can be dropped. It can raise a synchronous abort. It can be deferred by setting a sticky flag. Or the outcome can depend on the access direction: loads abort and stores are deferred. A synchronous abort appears one cycle after the strobe as a single-cycle pulse. The pulse carries a fixed fault status code, the write flag and the faulting address. A deferred failure sets one flag in the status register of the failing level. When the regime has two address ranges, an address bit chooses the flag. Software reads and clears the per-level status registers through a small register port.

Top module: `tcfp_unit`

## Requirements
- R1: The mode is `ctrl_word[39:38]` when `fail_level` is 0 and `ctrl_word[41:40]` for levels 1 to 3.
- R2: With mode 0 a failure raises no abort and changes no status flag.
- R3: With mode 1 every failure raises an abort and changes no status flag.
- R4: With mode 2 every failure sets a status flag and raises no abort.
- R5: With mode 3 a store failure (`fail_is_store`=1) sets a status flag without an abort, and a load failure raises an abort without setting a flag.
- R6: An abort is `abort_valid` high for exactly the one cycle after the failure strobe. In that cycle `abort_fsc` is 0x11, `abort_wnr` equals the store flag and `abort_addr` equals the faulting address.
- R7: A deferred failure sets bit `fail_addr[55]` of the failing level's status register when `two_ranges` is 1, and bit 0 otherwise. Bits already set stay set, and the registers of other levels are unchanged.
- R8: A register-port write (`reg_wr`) to level `reg_sel` clears each status bit whose `reg_wdata` bit is 1 and leaves the bits written with 0 unchanged.
- R9: If a failure sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: After reset every status register reads 0 and `abort_valid` is low.
- R11: `reg_rdata` always shows the status register of the level on `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_valid | input | 1 | Tag check failure strobe |
| fail_addr | input | 64 | Faulting virtual address |
| fail_is_store | input | 1 | 1 for a store, 0 for a load |
| fail_level | input | 2 | Exception level of the access |
| two_ranges | input | 1 | Regime has two address ranges |
| ctrl_word | input | 64 | System control word for the regime |
| reg_wr | input | 1 | Status write-1-to-clear strobe |
| reg_sel | input | 2 | Status register level selector |
| reg_wdata | input | 2 | Clear mask |
| reg_rdata | output | 2 | Selected status register |
| abort_valid | output | 1 | Synchronous abort pulse |
| abort_fsc | output | 6 | Fault status code |
| abort_wnr | output | 1 | Abort was caused by a store |
| abort_addr | output | 64 | Faulting address of the abort |

## Verification
A deferred failure and a register-port clear can land on the same status register in the same cycle. The bench provokes this in directed cases where the clear mask covers the bit being set and in cases where it covers only the other bit. It also mixes both events at random levels. A reference model applies the clear first and the set second, and the bench compares its result with the register read back in the following cycle.

// File: rtl/tcfp_pkg.sv
package tcfp_pkg;
   typedef enum logic [1:0] {
      MODE_IGNORE = 2'd0,
      MODE_TRAP   = 2'd1,
      MODE_DEFER  = 2'd2,
      MODE_SPLIT  = 2'd3
   } tcf_mode_e;

   typedef struct packed {
      logic trap;
      logic defer;
   } tcf_action_s;
endpackage

// File: rtl/tcfp_mode_sel.sv
module tcfp_mode_sel #(
   parameter int CTRL_W     = 64,
   parameter int LVL_W      = 2,
   parameter int UNPRIV_LSB = 38,
   parameter int PRIV_LSB   = 40
) (
   input  logic [CTRL_W-1:0]   ctrl_word,
   input  logic [LVL_W-1:0]    level,
   output tcfp_pkg::tcf_mode_e mode
);
   initial begin
      if (UNPRIV_LSB + 2 > CTRL_W || PRIV_LSB + 2 > CTRL_W)
         $error("tcfp_mode_sel: mode field outside control word");
   end

   always_comb begin
      if (level == '0) mode = tcfp_pkg::tcf_mode_e'(ctrl_word[UNPRIV_LSB +: 2]);
      else             mode = tcfp_pkg::tcf_mode_e'(ctrl_word[PRIV_LSB +: 2]);
   end
endmodule

// File: rtl/tcfp_decide.sv
module tcfp_decide (
   input  logic                  strobe,
   input  logic                  is_store,
   input  tcfp_pkg::tcf_mode_e   mode,
   output tcfp_pkg::tcf_action_s act
);
   always_comb begin
      act = '0;
      if (strobe) begin
         unique case (mode)
            tcfp_pkg::MODE_IGNORE: act = '0;
            tcfp_pkg::MODE_TRAP:   act.trap = 1'b1;
            tcfp_pkg::MODE_DEFER:  act.defer = 1'b1;
            tcfp_pkg::MODE_SPLIT: begin
               act.defer = is_store;
               act.trap  = ~is_store;
            end
            default: act = '0;
         endcase
      end
   end
endmodule

// File: rtl/tcfp_status_bank.sv
module tcfp_status_bank #(
   parameter int LEVELS = 4,
   parameter int FLAG_W = 2,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [LVL_W-1:0]  set_level,
   input  logic              set_hi,
   input  logic              clr_en,
   input  logic [LVL_W-1:0]  clr_level,
   input  logic [FLAG_W-1:0] clr_mask,
   input  logic [LVL_W-1:0]  rd_level,
   output logic [FLAG_W-1:0] rd_data
);
   logic [FLAG_W-1:0] flags [LEVELS];
   logic [FLAG_W-1:0] set_bits;

   always_comb begin
      set_bits = '0;
      set_bits[set_hi ? 1 : 0] = 1'b1;
   end

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      logic [FLAG_W-1:0] clr_here, set_here;
      always_comb begin
         clr_here = (clr_en && clr_level == LVL_W'(g)) ? clr_mask : '0;
         set_here = (set_en && set_level == LVL_W'(g)) ? set_bits : '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[g] <= '0;
         else        flags[g] <= (flags[g] & ~clr_here) | set_here;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < LEVELS; k++)
         if (rd_level == LVL_W'(k)) rd_data = flags[k];
   end
endmodule

// File: rtl/tcfp_abort_reg.sv
module tcfp_abort_reg #(
   parameter int ADDR_W = 64,
   parameter int FSC_W  = 6,
   parameter logic [FSC_W-1:0] FSC_VAL = 6'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              is_store,
   input  logic [ADDR_W-1:0] addr,
   output logic              abort_valid,
   output logic [FSC_W-1:0]  abort_fsc,
   output logic              abort_wnr,
   output logic [ADDR_W-1:0] abort_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_valid <= 1'b0;
         abort_fsc   <= '0;
         abort_wnr   <= 1'b0;
         abort_addr  <= '0;
      end else begin
         abort_valid <= fire;
         if (fire) begin
            abort_fsc  <= FSC_VAL;
            abort_wnr  <= is_store;
            abort_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/tcfp_unit.sv
module tcfp_unit #(
   parameter int ADDR_W     = 64,
   parameter int CTRL_W     = 64,
   parameter int LEVELS     = 4,
   parameter int SEL_BIT    = 55,
   parameter int UNPRIV_LSB = 38,
   parameter int PRIV_LSB   = 40,
   parameter int FSC_W      = 6,
   parameter logic [FSC_W-1:0] FSC_VAL = 6'h11,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int FLAG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fail_valid,
   input  logic [ADDR_W-1:0] fail_addr,
   input  logic              fail_is_store,
   input  logic [LVL_W-1:0]  fail_level,
   input  logic              two_ranges,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              reg_wr,
   input  logic [LVL_W-1:0]  reg_sel,
   input  logic [FLAG_W-1:0] reg_wdata,
   output logic [FLAG_W-1:0] reg_rdata,
   output logic              abort_valid,
   output logic [FSC_W-1:0]  abort_fsc,
   output logic              abort_wnr,
   output logic [ADDR_W-1:0] abort_addr
);
   initial begin
      if (SEL_BIT >= ADDR_W) $error("tcfp_unit: SEL_BIT beyond address");
      if (LEVELS < 2)        $error("tcfp_unit: need at least two levels");
   end

   tcfp_pkg::tcf_mode_e   mode;
   tcfp_pkg::tcf_action_s act;

   tcfp_mode_sel #(.CTRL_W(CTRL_W), .LVL_W(LVL_W),
                   .UNPRIV_LSB(UNPRIV_LSB), .PRIV_LSB(PRIV_LSB)) u_mode (
      .ctrl_word(ctrl_word), .level(fail_level), .mode(mode));

   tcfp_decide u_dec (
      .strobe(fail_valid), .is_store(fail_is_store), .mode(mode), .act(act));

   tcfp_status_bank #(.LEVELS(LEVELS), .FLAG_W(FLAG_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(act.defer), .set_level(fail_level),
      .set_hi(two_ranges & fail_addr[SEL_BIT]),
      .clr_en(reg_wr), .clr_level(reg_sel), .clr_mask(reg_wdata),
      .rd_level(reg_sel), .rd_data(reg_rdata));

   tcfp_abort_reg #(.ADDR_W(ADDR_W), .FSC_W(FSC_W), .FSC_VAL(FSC_VAL)) u_abort (
      .clk(clk), .rst_n(rst_n), .fire(act.trap), .is_store(fail_is_store),
      .addr(fail_addr), .abort_valid(abort_valid), .abort_fsc(abort_fsc),
      .abort_wnr(abort_wnr), .abort_addr(abort_addr));
endmodule

// File: rtl/tcfp_chk.sv
module tcfp_chk #(
   parameter int ADDR_W = 64, parameter int CTRL_W = 64, parameter int LVL_W = 2,
   parameter int UNPRIV_LSB = 38, parameter int PRIV_LSB = 40, parameter int FSC_W = 6
) (
   input logic clk, input logic rst_n, input logic fail_valid,
   input logic [ADDR_W-1:0] fail_addr, input logic fail_is_store,
   input logic [LVL_W-1:0] fail_level, input logic [CTRL_W-1:0] ctrl_word,
   input logic reg_wr, input logic [LVL_W-1:0] reg_sel, input logic [1:0] reg_wdata,
   input logic [1:0] reg_rdata, input logic abort_valid,
   input logic [FSC_W-1:0] abort_fsc, input logic abort_wnr,
   input logic [ADDR_W-1:0] abort_addr
);
   logic [1:0] m;
   assign m = (fail_level == '0) ? ctrl_word[UNPRIV_LSB +: 2] : ctrl_word[PRIV_LSB +: 2];

   // R2
   ignore_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && m == 2'd0 |=> !abort_valid);
   // R3
   trap_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && m == 2'd1 |=> abort_valid);
   // R4
   defer_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && m == 2'd2 |=> !abort_valid);
   // R5
   split_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && m == 2'd3 |=> abort_valid == !$past(fail_is_store));
   // R6
   abort_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_valid |-> $past(fail_valid) && abort_addr == $past(fail_addr)
                      && abort_wnr == $past(fail_is_store) && abort_fsc == 6'h11);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !fail_valid |=> reg_sel != $past(reg_sel) || (reg_rdata & $past(reg_wdata)) == 2'b00);
endmodule

bind tcfp_unit tcfp_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .LVL_W(LVL_W),
   .UNPRIV_LSB(UNPRIV_LSB), .PRIV_LSB(PRIV_LSB), .FSC_W(FSC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_addr(fail_addr),
   .fail_is_store(fail_is_store), .fail_level(fail_level), .ctrl_word(ctrl_word),
   .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .abort_valid(abort_valid), .abort_fsc(abort_fsc), .abort_wnr(abort_wnr),
   .abort_addr(abort_addr));

// File: tb/sim_tcfp_unit.sv
`timescale 1ns/1ps
module sim_tcfp_unit;
   logic clk = 0, rst_n = 0;
   logic fail_valid = 0, fail_is_store = 0, two_ranges = 0, reg_wr = 0;
   logic [63:0] fail_addr = 0, ctrl_word = 0, abort_addr;
   logic [1:0] fail_level = 0, reg_sel = 0, reg_wdata = 0, reg_rdata;
   logic abort_valid, abort_wnr;
   logic [5:0] abort_fsc;
   int checks = 0, errors = 0;
   bit done = 0;
   logic [1:0] mdl [4];

   always #5 clk = ~clk;

   tcfp_unit u0 (.*);

   function automatic logic [1:0] mode_of(logic [63:0] cw, logic [1:0] lvl);
      return (lvl == 0) ? cw[39:38] : cw[41:40];
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(logic fv, logic [63:0] a, logic st, logic [1:0] lvl, logic tr,
                       logic [63:0] cw, logic wr, logic [1:0] sel, logic [1:0] wd);
      logic [1:0] md;
      logic trap, defer;
      @(negedge clk);
      fail_valid = fv; fail_addr = a; fail_is_store = st; fail_level = lvl;
      two_ranges = tr; ctrl_word = cw; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      md = mode_of(cw, lvl);
      trap  = fv && (md == 1 || (md == 3 && !st));
      defer = fv && (md == 2 || (md == 3 && st));
      if (wr) mdl[sel] = mdl[sel] & ~wd;          // R8 clear first
      if (defer) mdl[lvl][(tr && a[55]) ? 1 : 0] = 1'b1;  // R7, R9 set wins
      @(posedge clk); #1;
      chk("R1/R3/R5 abort_valid", abort_valid, trap);
      if (trap) begin
         chk("R6 fsc", abort_fsc, 6'h11);
         chk("R6 wnr", abort_wnr, st);
         chk("R6 addr", abort_addr, a);
      end
      chk("R2/R4/R7/R9/R11 flags", reg_rdata, mdl[sel]);
      fail_valid = 0; reg_wr = 0;
      @(posedge clk); #1;
      chk("R6 single pulse", abort_valid, 0);
   endtask

   task automatic read_all(string req);
      for (int l = 0; l < 4; l++) begin
         @(negedge clk); reg_sel = 2'(l); #1;
         chk(req, reg_rdata, mdl[l]);
      end
   endtask

   function automatic logic [63:0] cw_m(logic [1:0] u, logic [1:0] p);
      logic [63:0] w = 64'h5A5A_F00F_0000_1234;
      w[39:38] = u; w[41:40] = p;
      return w;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] hi = 64'h0080_0000_0000_1000;   // bit 55 set
      logic [63:0] lo = 64'h0000_0000_0000_2040;
      void'($urandom(32'd1234));
      for (int l = 0; l < 4; l++) mdl[l] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 abort after reset", abort_valid, 0);
      read_all("R10 flags after reset");
      @(negedge clk); rst_n = 1;
      // R1: level 0 uses low field, others high field
      step(1, lo, 0, 0, 0, cw_m(2'd1, 2'd0), 0, 0, 0);
      step(1, lo, 0, 2, 0, cw_m(2'd1, 2'd0), 0, 2, 0);   // R2 ignore at level 2
      step(1, hi, 1, 1, 0, cw_m(2'd0, 2'd1), 0, 1, 0);   // R3 trap store
      // R4 defer, R7 bit choice
      step(1, hi, 0, 1, 1, cw_m(2'd0, 2'd2), 0, 1, 0);
      step(1, hi, 0, 1, 0, cw_m(2'd0, 2'd2), 0, 1, 0);
      step(1, lo, 0, 3, 1, cw_m(2'd0, 2'd2), 0, 3, 0);
      // R5 split
      step(1, hi, 1, 0, 1, cw_m(2'd3, 2'd0), 0, 0, 0);
      step(1, lo, 0, 0, 1, cw_m(2'd3, 2'd0), 0, 0, 0);
      read_all("R7 other levels untouched");
      // R8 partial clear keeps zero-written bit
      step(0, 0, 0, 0, 0, 0, 1, 1, 2'b01);
      step(0, 0, 0, 0, 0, 0, 1, 1, 2'b10);
      // R9 same-cycle set and clear
      step(1, hi, 1, 2, 1, cw_m(2'd0, 2'd2), 1, 2, 2'b11);
      step(1, lo, 1, 2, 1, cw_m(2'd0, 2'd3), 1, 2, 2'b10);
      // R6 back-to-back aborts
      @(negedge clk);
      fail_valid = 1; fail_addr = 64'h1111; fail_is_store = 0; fail_level = 1;
      ctrl_word = cw_m(2'd0, 2'd1);
      @(negedge clk); fail_addr = 64'h2222; fail_is_store = 1;
      #1; chk("R6 b2b first", abort_addr, 64'h1111);
      @(negedge clk); fail_valid = 0;
      #1; chk("R6 b2b second", abort_addr, 64'h2222);
      chk("R6 b2b wnr", abort_wnr, 1);
      @(negedge clk); #1; chk("R6 b2b end", abort_valid, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a = {$urandom, $urandom};
         step($urandom_range(0, 3) != 0, a, 1'($urandom), 2'($urandom), 1'($urandom),
              {$urandom, $urandom}, $urandom_range(0, 2) == 0, 2'($urandom), 2'($urandom));
      end
      read_all("R11 final readback");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule